// File: doc/BRIEF.md
# Two-Wire Bus Slave Receiver

This block is a receive-only slave port for a two-wire serial bus. It watches the clock line (SCL) and the data line (SDA) from an external master and finds START, repeated START and STOP conditions. It shifts in the address byte and compares it with a programmable own address and with the general call address. Each byte it accepts is copied into a receive buffer at the moment the acknowledge bit goes out. Depending on a host control input, the port answers that byte with ACK or NAK.

The host sees five flags: byte ready, address matched, STOP seen, interrupt and overrun. Each flag has its own one-cycle clear input. The address byte and the data bytes share the one buffer and the one ready flag. The address-matched flag marks the address byte. The host can read the buffer to tell a hit on its own address from a general call. The port never stretches the clock, never transmits data and never acts as master.

Top module: `twire_slave_rx`

## Requirements
- R1: After reset, all five flags and `sda_oe` are 0 and `rx_data` is 0x00.
- R2: A START (SDA falling while SCL is high) or a repeated START begins an address phase. Bits are sampled on the SCL rising edge, most significant bit first, and eight bits make one byte.
- R3: The address byte is accepted when its bits [7:1] equal `own_addr[7:1]` or are all zero (general call) and its bit 0 (direction) is 0. `own_addr[0]` is ignored. An accepted address byte is written to `rx_data` and sets `rx_ready` and `addr_match`.
- R4: For an accepted byte, if `nak_ctl` is 0 the port drives `sda_oe` high from the 8th SCL falling edge to the 9th SCL falling edge, which is an ACK. If `nak_ctl` is 1, `sda_oe` stays low (NAK) but the byte is still loaded.
- R5: Each data byte after an accepted address is written to `rx_data` and sets `rx_ready` at its acknowledge time. `clr_rx` clears `rx_ready`.
- R6: A non-matching address or a direction bit of 1 gets no acknowledge and changes no flag. Later bytes are ignored until the next START or STOP. Bytes clocked while idle are ignored.
- R7: A STOP received while the port is addressed sets `stop_seen` and returns the port to idle. A STOP received while the port is not addressed sets nothing. `clr_stop` clears `stop_seen`.
- R8: `irq` is set by every byte load and by every setting of `stop_seen`. `clr_irq` clears it, and `clr_addr` clears `addr_match`.
- R9: A byte load while `rx_ready` is 1 and `clr_rx` is 0 overwrites `rx_data` and sets `overrun`, which stays set until `clr_ovr`.
- R10: When a byte load and `clr_rx` fall in the same cycle, `rx_ready` ends set and `overrun` is not set.
- R11: `sda_oe` rises only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen on the wire, asynchronous |
| own_addr | input | 8 | Own 7-bit address in bits [7:1]; bit 0 unused |
| nak_ctl | input | 1 | 1: answer accepted bytes with NAK |
| clr_rx | input | 1 | Clear `rx_ready` |
| clr_addr | input | 1 | Clear `addr_match` |
| clr_stop | input | 1 | Clear `stop_seen` |
| clr_irq | input | 1 | Clear `irq` |
| clr_ovr | input | 1 | Clear `overrun` |
| sda_oe | output | 1 | 1: pull SDA low |
| rx_data | output | 8 | Receive buffer |
| rx_ready | output | 1 | A byte is waiting in the buffer |
| addr_match | output | 1 | The address byte was accepted |
| stop_seen | output | 1 | STOP ended an addressed transfer |
| irq | output | 1 | Interrupt flag |
| overrun | output | 1 | An unread byte was overwritten |

## Verification
A byte load and a host clear of `rx_ready` can land in the same clock cycle, and this is the collision that matters. The bench knows the synchronizer and edge-detect latency: the load follows an SCL fall by three clocks. It therefore pulses `clr_rx` exactly on the cycle in which the 8th falling edge of a data byte takes effect. The reference model judges the result by the rule that the set wins: `rx_ready` must stay 1 and `overrun` must not rise. The per-clock comparison then confirms this in every following cycle.

// File: rtl/twire_slave_rx.sv
module twire_slave_rx (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [7:0] own_addr,
  input  logic       nak_ctl,
  input  logic       clr_rx,
  input  logic       clr_addr,
  input  logic       clr_stop,
  input  logic       clr_irq,
  input  logic       clr_ovr,
  output logic       sda_oe,
  output logic [7:0] rx_data,
  output logic       rx_ready,
  output logic       addr_match,
  output logic       stop_seen,
  output logic       irq,
  output logic       overrun
);

  typedef enum logic [2:0] {IDLE, ADDR, DATA, ACK, SKIP} st_t;

  st_t        st;
  logic [1:0] scl_sy, sda_sy;
  logic       scl_d, sda_d;
  logic [3:0] cnt;
  logic [7:0] sh;

  wire scl     = scl_sy[1];
  wire sda     = sda_sy[1];
  wire start_c = scl & scl_d & sda_d & ~sda;
  wire stop_c  = scl & scl_d & ~sda_d & sda;
  wire rise    = scl & ~scl_d;
  wire fall    = ~scl & scl_d;

  wire in_byte   = (st == ADDR) || (st == DATA);
  wire byte_done = fall && in_byte && (cnt == 4'd8) && !start_c && !stop_c;
  wire hit       = ((((sh ^ own_addr) & 8'hFE) == 8'h00) || ((sh & 8'hFE) == 8'h00)) && !sh[0];
  wire load      = byte_done && ((st == DATA) || hit);
  wire stop_ev   = stop_c && ((st == DATA) || (st == ACK));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      scl_sy <= 2'b11;
      sda_sy <= 2'b11;
      scl_d  <= 1'b1;
      sda_d  <= 1'b1;
    end else begin
      scl_sy <= {scl_sy[0], scl_i};
      sda_sy <= {sda_sy[0], sda_i};
      scl_d  <= scl;
      sda_d  <= sda;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= IDLE;
      cnt    <= '0;
      sh     <= '0;
      sda_oe <= 1'b0;
    end else if (stop_c) begin
      st     <= IDLE;
      sda_oe <= 1'b0;
    end else if (start_c) begin
      st     <= ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
    end else begin
      case (st)
        ADDR, DATA: begin
          if (rise && cnt < 4'd8) begin
            sh  <= {sh[6:0], sda};
            cnt <= cnt + 4'd1;
          end else if (byte_done) begin
            if (load) begin
              st     <= ACK;
              sda_oe <= ~nak_ctl;
            end else begin
              st <= SKIP;
            end
          end
        end
        ACK: if (fall) begin
          st     <= DATA;
          cnt    <= '0;
          sda_oe <= 1'b0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data    <= '0;
      rx_ready   <= 1'b0;
      addr_match <= 1'b0;
      stop_seen  <= 1'b0;
      irq        <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      if (load) rx_data <= sh;
      rx_ready   <= load ? 1'b1 : (clr_rx ? 1'b0 : rx_ready);
      addr_match <= (load && st == ADDR) ? 1'b1 : (clr_addr ? 1'b0 : addr_match);
      stop_seen  <= stop_ev ? 1'b1 : (clr_stop ? 1'b0 : stop_seen);
      irq        <= (load || stop_ev) ? 1'b1 : (clr_irq ? 1'b0 : irq);
      overrun    <= (load && rx_ready && !clr_rx) ? 1'b1 : (clr_ovr ? 1'b0 : overrun);
    end
  end

  assert_oe_scl_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl);

  assert_match_loads_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(addr_match) |-> (rx_ready && !rx_data[0]));

  assert_load_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ready) |-> irq);

  assert_stop_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stop_seen) |-> (!sda_oe && irq));

  assert_overrun_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> rx_ready);

endmodule

// File: tb/test_twire_slave_rx.sv
module test_twire_slave_rx;
  localparam int CLK_PERIOD = 10;
  localparam int H = 8;

  logic clk = 0, rst_n = 0;
  logic scl = 1, sda_m = 1;
  logic [7:0] own_addr = 8'h5B;
  logic nak_ctl = 0, clr_rx = 0, clr_addr = 0, clr_stop = 0, clr_irq = 0, clr_ovr = 0;
  logic sda_oe, rx_ready, addr_match, stop_seen, irq, overrun;
  logic [7:0] rx_data;
  wire sda_line = sda_m & ~sda_oe;

  twire_slave_rx i_twire_slave_rx (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .own_addr(own_addr),
    .nak_ctl(nak_ctl), .clr_rx(clr_rx), .clr_addr(clr_addr), .clr_stop(clr_stop),
    .clr_irq(clr_irq), .clr_ovr(clr_ovr), .sda_oe(sda_oe), .rx_data(rx_data),
    .rx_ready(rx_ready), .addr_match(addr_match), .stop_seen(stop_seen),
    .irq(irq), .overrun(overrun));

  always #(CLK_PERIOD/2) clk = ~clk;

  int vectors = 0, errs = 0, cyc = 0, drv_cyc = 0;
  int m_state = 0;
  logic e_oe = 0, e_rdy = 0, e_am = 0, e_stop = 0, e_irq = 0, e_ovr = 0;
  logic [7:0] e_dat = 0;
  bit mon_on = 0;

  task automatic chk(string r, logic [7:0] act, logic [7:0] exp, string what);
    vectors++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %h expected %h at cycle %0d", r, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    cyc = cyc + 1;
    #1;
    if (mon_on && (cyc - drv_cyc >= 4)) begin
      chk("R4", {7'd0, sda_oe}, {7'd0, e_oe}, "sda_oe");
      chk("R5", {7'd0, rx_ready}, {7'd0, e_rdy}, "rx_ready");
      chk("R3", {7'd0, addr_match}, {7'd0, e_am}, "addr_match");
      chk("R7", {7'd0, stop_seen}, {7'd0, e_stop}, "stop_seen");
      chk("R8", {7'd0, irq}, {7'd0, e_irq}, "irq");
      chk("R9", {7'd0, overrun}, {7'd0, e_ovr}, "overrun");
      chk("R2", rx_data, e_dat, "rx_data");
    end
  end

  task automatic wt(int n); repeat (n) @(negedge clk); endtask
  task automatic mark(); drv_cyc = cyc; endtask

  task automatic ld(logic [7:0] b, bit collide);
    if (e_rdy && !collide) e_ovr = 1;
    e_rdy = 1; e_dat = b; e_irq = 1;
  endtask

  task automatic bstart();
    sda_m = 0; mark(); m_state = 1; wt(H);
    scl = 0; mark(); wt(H);
  endtask

  task automatic brestart();
    sda_m = 1; mark(); wt(H);
    scl = 1; mark(); wt(H);
    bstart();
  endtask

  task automatic bstop();
    sda_m = 0; mark(); wt(H);
    scl = 1; mark(); wt(H);
    sda_m = 1; mark();
    if (m_state == 2) begin e_stop = 1; e_irq = 1; end
    m_state = 0; wt(H);
  endtask

  task automatic send_byte(logic [7:0] b, bit collide, string r);
    logic ack;
    ack = 0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; mark(); wt(H);
      scl = 1; mark(); wt(H);
      scl = 0; mark();
      if (i == 0) begin
        if (m_state == 1) begin
          if ((b[7:1] == own_addr[7:1] || b[7:1] == 7'd0) && !b[0]) begin
            ld(b, collide); e_am = 1; ack = !nak_ctl; m_state = 2;
          end else m_state = 3;
        end else if (m_state == 2) begin
          ld(b, collide); ack = !nak_ctl;
        end
        e_oe = ack;
        if (collide) begin
          wt(2); clr_rx = 1; mark(); wt(1); clr_rx = 0; mark(); wt(H - 3);
        end else wt(H);
      end else wt(H);
    end
    sda_m = 1; mark(); wt(H);
    scl = 1; mark(); wt(H/2);
    chk(r, {7'd0, sda_oe}, {7'd0, ack}, "acknowledge drive on 9th clock");
    wt(H/2);
    scl = 0; mark(); e_oe = 0; wt(H);
  endtask

  task automatic clear(bit r, bit a, bit s, bit i, bit o);
    clr_rx = r; clr_addr = a; clr_stop = s; clr_irq = i; clr_ovr = o; mark(); wt(1);
    clr_rx = 0; clr_addr = 0; clr_stop = 0; clr_irq = 0; clr_ovr = 0; mark();
    if (r) e_rdy = 0;
    if (a) e_am = 0;
    if (s) e_stop = 0;
    if (i) e_irq = 0;
    if (o) e_ovr = 0;
    wt(2);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errs++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end

  initial begin
    wt(4);
    rst_n = 1; mark(); wt(2);
    // R1: reset state
    chk("R1", {2'd0, sda_oe, rx_ready, addr_match, stop_seen, irq, overrun}, 8'd0, "flags after reset");
    chk("R1", rx_data, 8'h00, "rx_data after reset");
    mon_on = 1; wt(6);

    // R3: own address 0x5B, bit 0 ignored, byte 0x5A accepted
    bstart();
    send_byte(8'h5A, 0, "R3");
    clear(1, 1, 0, 1, 0);
    // R5: data byte
    send_byte(8'h3C, 0, "R5");
    clear(1, 0, 0, 1, 0);
    // R4: NAK under nak_ctl, byte still loaded
    nak_ctl = 1; mark();
    send_byte(8'h81, 0, "R4");
    nak_ctl = 0; mark();
    // R9: load while rx_ready still set
    send_byte(8'h11, 0, "R9");
    clear(1, 0, 0, 1, 1);
    // R7: STOP while addressed
    bstop();
    wt(4);
    clear(0, 0, 1, 1, 0);

    // R3: general call, then R10 collision of load and clear
    bstart();
    send_byte(8'h00, 0, "R3");
    send_byte(8'hF0, 1, "R10");
    chk("R10", {7'd0, rx_ready}, 8'd1, "rx_ready after same-cycle set and clear");
    chk("R10", {7'd0, overrun}, 8'd0, "overrun after same-cycle set and clear");
    clear(1, 1, 0, 1, 0);
    // R6: repeated START with read direction is ignored
    brestart();
    send_byte(8'h5B, 0, "R6");
    send_byte(8'h77, 0, "R6");
    bstop();
    wt(4);
    chk("R7", {7'd0, stop_seen}, 8'd0, "stop while not addressed");

    // R6: address mismatch
    bstart();
    send_byte(8'h20, 0, "R6");
    send_byte(8'h99, 0, "R6");
    bstop();

    // R6: byte clocked while idle
    scl = 0; mark(); wt(H);
    send_byte(8'hA5, 0, "R6");
    sda_m = 1; mark(); wt(H);
    scl = 1; mark(); wt(H);
    chk("R6", rx_data, 8'hF0, "buffer unchanged by ignored bytes");

    // R2: addressed again after idle, MSB-first data
    bstart();
    send_byte(8'h5A, 0, "R2");
    send_byte(8'hC3, 0, "R2");
    chk("R2", rx_data, 8'hC3, "MSB-first data byte");
    bstop();
    wt(6);
    chk("R8", {7'd0, irq}, 8'd1, "irq after stop");
    clear(1, 1, 1, 1, 1);
    wt(6);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errs);
    $finish;
  end
endmodule